// File: doc/BRIEF.md
# Boot key serial transmitter

This block forces a target chip into its built-in bootloader by bit-banging a fixed 16-bit key onto the two USB data pins. D+ serves as a slow serial clock. D- carries the data bit. The target latches D- on each rising edge of D+. The key goes out most significant bit first and repeats frame after frame. After each frame, both pins are released, with the pull-ups holding them high, for one bit time. In that window the block listens for the target's acknowledge, which pulls both pins low together for roughly 1 to 2 ms.

The system clock rate, the bit rate, the acknowledge debounce and the overall timeout are all parameters. The half-period count is the system clock divided by twice the bit rate. Each sensed pin level passes through a two-flip-flop synchroniser.

A released window in which both pins read low places the block in a hold state with the pins still released. If the lows persist for the full debounce time, the block stops and raises `done`. If either pin rises first, a new frame starts from the MSB. If no acknowledge completes within the timeout, the block raises `err` and returns to idle.

Top module: `bootkey_tx`

## Requirements
- R1: After reset, and whenever the block is idle, both drive enables are 0 and `busy`, `done` and `err` are 0 (or hold their last result). A `start` pulse seen while idle makes `busy` 1 on the next cycle. A `start` pulse while busy has no effect.
- R2: While a frame is sent, both pins are driven (`dp_oe`=`dm_oe`=1). For each bit, D+ is low for HALF = CLK_HZ/(2*BIT_HZ) cycles and then high for HALF cycles.
- R3: D- carries the key 16'h16EF, most significant bit first, bit 15 in the first bit time. D- changes only while D+ is low, so it is stable across each rising edge of D+.
- R4: After the 16th bit, both pins are released for 2*HALF cycles. The next frame then starts again at bit 15 with D+ low.
- R5: An acknowledge is looked for only in the released window, from its third cycle on. While a frame is driven, low levels on the sensed inputs change nothing.
- R6: Once both synchronised inputs read low in the window, the pins stay released. If both stay low for DEB = (CLK_HZ/1e6)*DEB_US further cycles, the block goes idle with `done`=1.
- R7: If either synchronised input reads high during that hold, a fresh frame starts at bit 15 on the next cycle, and `done` stays 0.
- R8: If `done` has not been reached (CLK_HZ/1e6)*TIMEOUT_US cycles after `start`, the block goes idle with `err`=1.
- R9: A new `start` clears both `done` and `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin sending the key |
| dp_in | input | 1 | Sensed level of D+ (asynchronous) |
| dm_in | input | 1 | Sensed level of D- (asynchronous) |
| dp_oe | output | 1 | Drive enable for D+ |
| dp_out | output | 1 | Drive level for D+ (serial clock) |
| dm_oe | output | 1 | Drive enable for D- |
| dm_out | output | 1 | Drive level for D- (key data) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Acknowledge accepted |
| err | output | 1 | Timeout without acknowledge |

## Verification
The assertions take for granted three things:
- `start` is a synchronous pulse.
- A driven pin reads back the driven level, so an acknowledge can only appear on a released pin.
- The sensed inputs may change at any cycle.

The stimulus follows this model: a pin reads its drive level while enabled, and otherwise reads high unless the bench's acknowledge pull-down is active. Acknowledge pulses are placed inside a frame, at the start of a released window, and as a short glitch shorter than the debounce. A separate run with no acknowledge at all reaches the timeout.

// File: rtl/bootkey_tx.sv
module bootkey_tx #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BIT_HZ     = 50_000,
  parameter int DEB_US     = 500,
  parameter int TIMEOUT_US = 100_000,
  parameter int KEY_W      = 16,
  parameter logic [KEY_W-1:0] KEY = 16'h16EF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dp_in,
  input  logic dm_in,
  output logic dp_oe,
  output logic dp_out,
  output logic dm_oe,
  output logic dm_out,
  output logic busy,
  output logic done,
  output logic err
);
  localparam int HALF = CLK_HZ / (2 * BIT_HZ);
  localparam int GAPC = 2 * HALF;
  localparam int DEB  = (CLK_HZ / 1_000_000) * DEB_US;
  localparam int TOC  = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int HW   = $clog2(GAPC + 1);
  localparam int DW   = $clog2(DEB + 1);
  localparam int TW   = $clog2(TOC + 1);
  localparam int BW   = (KEY_W > 1) ? $clog2(KEY_W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP, S_HOLD} st_t;

  st_t           st;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] tcnt;
  logic          ph;
  logic [1:0]    dp_sy, dm_sy;
  logic          dp_s, dm_s, both_low, fin;

  assign dp_s     = dp_sy[1];
  assign dm_s     = dm_sy[1];
  assign both_low = !dp_s && !dm_s;
  assign fin      = (st == S_HOLD) && both_low && (dcnt == DW'(DEB - 1));

  assign dp_oe  = (st == S_SEND);
  assign dm_oe  = (st == S_SEND);
  assign dp_out = (st == S_SEND) && ph;
  assign dm_out = (st == S_SEND) && KEY[bidx];
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_sy <= 2'b11;
      dm_sy <= 2'b11;
    end else begin
      dp_sy <= {dp_sy[0], dp_in};
      dm_sy <= {dm_sy[0], dm_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hcnt <= '0;
      bidx <= '0;
      dcnt <= '0;
      tcnt <= '0;
      ph   <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            st   <= S_SEND;
            hcnt <= '0;
            ph   <= 1'b0;
            bidx <= BW'(KEY_W - 1);
            tcnt <= '0;
            done <= 1'b0;
            err  <= 1'b0;
          end
        S_SEND:
          if (hcnt == HW'(HALF - 1)) begin
            hcnt <= '0;
            ph   <= !ph;
            if (ph) begin
              if (bidx == '0) st <= S_GAP;
              else bidx <= bidx - 1'b1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        S_GAP:
          if (hcnt >= HW'(2) && both_low) begin
            st   <= S_HOLD;
            dcnt <= '0;
          end else if (hcnt == HW'(GAPC - 1)) begin
            st   <= S_SEND;
            hcnt <= '0;
            ph   <= 1'b0;
            bidx <= BW'(KEY_W - 1);
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        S_HOLD:
          if (!both_low) begin
            st   <= S_SEND;
            hcnt <= '0;
            ph   <= 1'b0;
            bidx <= BW'(KEY_W - 1);
          end else if (fin) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
      if (st != S_IDLE && !fin) begin
        if (tcnt == TW'(TOC - 1)) begin
          st  <= S_IDLE;
          err <= 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end
endmodule

module bootkey_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic dp_oe,
  input logic dp_out,
  input logic dm_oe,
  input logic dm_out,
  input logic busy,
  input logic done,
  input logic err
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dp_oe && !dm_oe); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy); // R1
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dm_oe && $past(dm_oe) && !$stable(dm_out) |-> !dp_out); // R3
  AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_oe) && busy |-> $past(dp_out) && $past(dm_out)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && !dp_oe && !err); // R6
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !done); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> !done && !err); // R9
endmodule

bind bootkey_tx bootkey_tx_chk u_chk (.*);

// File: tb/sim_bootkey_tx.sv
`timescale 1ns/1ps
module sim_bootkey_tx;
  localparam int H   = 10;
  localparam int KW  = 16;
  localparam int DEB = 500;
  localparam int TO  = 20_000;
  localparam logic [15:0] KEYV = 16'h16EF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
  logic dp_in, dm_in, dp_oe, dp_out, dm_oe, dm_out, busy, done, err;
  int vec = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  assign dp_in = dp_oe ? dp_out : !ack;
  assign dm_in = dm_oe ? dm_out : !ack;

  bootkey_tx #(.CLK_HZ(1_000_000), .BIT_HZ(50_000), .DEB_US(500), .TIMEOUT_US(20_000)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dp_in(dp_in), .dm_in(dm_in),
    .dp_oe(dp_oe), .dp_out(dp_out), .dm_oe(dm_oe), .dm_out(dm_out),
    .busy(busy), .done(done), .err(err));

  int m_st = 0, m_t = 0, m_d = 0, m_to = 0;
  logic m_done = 0, m_err = 0;
  logic p1 = 1, p2 = 1, n1 = 1, n2 = 1;
  logic e_oe, e_dp, e_dm;

  always_comb begin
    e_oe = (m_st == 1) && (m_t < 2*H*KW);
    e_dp = e_oe && ((m_t % (2*H)) >= H);
    e_dm = e_oe && KEYV[KW-1 - m_t/(2*H)];
  end

  always @(posedge clk) begin
    logic sp, sn, lp, ln, fin;
    int was;
    lp = e_oe ? e_dp : !ack;
    ln = e_oe ? e_dm : !ack;
    sp = p2; sn = n2;
    p2 = p1; p1 = lp; n2 = n1; n1 = ln;
    fin = 0;
    was = m_st;
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_d = 0; m_to = 0; m_done = 0; m_err = 0;
      p1 = 1; p2 = 1; n1 = 1; n2 = 1;
    end else begin
      if (m_st == 0) begin
        if (start) begin m_st = 1; m_t = 0; m_to = 0; m_done = 0; m_err = 0; end
      end else if (m_st == 1) begin
        if (m_t >= 2*H*KW + 2 && !sp && !sn) begin m_st = 2; m_d = 0; end
        else if (m_t == 2*H*KW + 2*H - 1) m_t = 0;
        else m_t++;
      end else begin
        if (sp || sn) begin m_st = 1; m_t = 0; end
        else if (m_d == DEB-1) begin m_st = 0; m_done = 1; fin = 1; end
        else m_d++;
      end
      if (was != 0 && !fin) begin
        if (m_to == TO-1) begin m_st = 0; m_err = 1; end
        else m_to++;
      end
    end
  end

  task automatic chk(input string r, input logic a, input logic e);
    vec++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", r, cyc, a, e);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 dp_oe", dp_oe, e_oe);
      chk("R4 dm_oe", dm_oe, e_oe);
      chk("R2 dp_out", dp_out, e_dp);
      chk("R3 dm_out", dm_out, e_dm);
      chk("R1 busy", busy, m_st != 0);
      chk("R6 done", done, m_done);
      chk("R8 err", err, m_err);
    end
    if (cyc > 150_000) begin
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    chk("R1 reset oe", dp_oe | dm_oe, 1'b0);
    chk("R1 reset status", busy | done | err, 1'b0);
    rst_n = 1'b1;
    idle(3);
    pulse_start();
    chk("R1 busy after start", busy, 1'b1);
    idle(50);
    pulse_start();
    chk("R1 start ignored while busy", busy, 1'b1);
    idle(700);
    while (!(m_st == 1 && m_t == 2*H*KW)) @(negedge clk);
    ack = 1'b1;
    idle(100);
    ack = 1'b0;
    idle(4);
    chk("R7 glitch no done", done, 1'b0);
    chk("R7 resumed driving", dp_oe, 1'b1);
    idle(100);
    while (!(m_st == 1 && m_t == 5)) @(negedge clk);
    ack = 1'b1;
    idle(1);
    chk("R5 still driven during ack", dp_oe, 1'b1);
    idle(1500);
    ack = 1'b0;
    chk("R6 done set", done, 1'b1);
    chk("R6 released idle", busy | dp_oe, 1'b0);
    idle(10);
    pulse_start();
    chk("R9 done cleared", done, 1'b0);
    idle(TO + 50);
    chk("R8 err set", err, 1'b1);
    chk("R8 idle after timeout", busy, 1'b0);
    pulse_start();
    chk("R9 err cleared", err, 1'b0);
    idle(400);
    while (!(m_st == 1 && m_t == 2*H*KW)) @(negedge clk);
    ack = 1'b1;
    idle(DEB + 20);
    ack = 1'b0;
    chk("R6 done from gap", done, 1'b1);
    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule